// File: doc/BRIEF.md
# Local Bus Cycle Sequencer with Hold Arbitration

This block steps an 8-bit processor's local bus through its clock states. It runs the address phase T1, the command phase T2, the data phase T3, any number of wait states Tw, the closing state T4 and the idle state Ti. It drives a 3-bit cycle status code that an external bus controller decodes, and it drives output enables for the status pins, the multiplexed address/data pins and the control pins. A second bus master can ask for the bus through `hold_req`. The block grants it with `hold_ack` only at a clock boundary where no transfer is in flight.

The core posts a cycle by pulsing `req_valid` for one clock with a 3-bit `req_kind`. From an idle bus the code appears on `stat` while the bus is still in Ti. T1 follows on the next clock. A request that arrives before T4 is shown during T4 and follows it directly. The `hold_req` input is sampled on rising edges. Grants and releases of `hold_ack` happen on falling edges, which places them in the middle of a clock.

Top module: `bus_seq`

## Requirements
- R1: During the first clock after `rst` is sampled high, `stat_oe`=1 and `stat`=3'b111. For the rest of reset, and after it until a request arrives, `stat_oe`=0, `bus_oe`=0, `hold_ack`=0 and `phase`=Ti.
- R2: `phase` encodes Ti=0, T1=1, T2=2, T3=3, Tw=4, T4=5. A cycle runs T1, T2, T3, then zero or more Tw, then T4. `done` is 1 exactly while `phase` is T4.
- R3: A low `ready` sampled at the rising edge that ends T3 or Tw inserts one Tw state. The number of Tw states equals the number of consecutive low samples.
- R4: `stat` carries the cycle's code during T1 and T2. It carries 3'b111 (passive) during T3 and Tw.
- R5: `req_kind` codes 0 to 6 start a cycle. Code 7 is ignored, and so is a request made while one is already pending. In Ti a pending code appears on `stat` with `stat_oe`=1 in the clock after it is taken, and T1 follows one clock later.
- R6: A request taken before T4 is shown on `stat` during T4, and T4 is followed directly by T1.
- R7: `hold_req` is sampled on rising edges. `hold_ack` rises only at a falling edge inside T4 or Ti, never in the same half-clock as the sample.
- R8: Whenever `hold_ack` is 1, both `bus_oe` and `stat_oe` are 0, from the same falling edge on.
- R9: A cycle that has started completes through T4 before `hold_ack` rises. While `hold_ack` is 1 the sequencer stays in Ti, even with a request pending.
- R10: After `hold_req` is sampled low, `hold_ack` falls at the next falling edge. `bus_oe` stays 0 until the T1 of a new cycle, and `stat_oe` stays 0 unless a request is pending.
- R11: `bus_oe` rises with T1 and stays 1 through idle clocks until hold is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-clock pulse posting a bus cycle |
| req_kind | input | 3 | Cycle code for the posted cycle (7 is not a cycle) |
| ready | input | 1 | Target ready; low extends T3 with Tw states |
| hold_req | input | 1 | Other master requests the bus (synchronous) |
| stat | output | 3 | Cycle status code, 3'b111 when passive |
| stat_oe | output | 1 | Drive enable for the status pins |
| bus_oe | output | 1 | Drive enable for the address/data and control pins |
| hold_ack | output | 1 | Bus granted to the other master |
| done | output | 1 | High during T4 of each cycle |
| phase | output | 3 | Current clock state |

## Verification
A wrong sequencer state shows on `phase` and `stat` in the same clock it occurs, and a missed or extra wait state shows as a wrong Tw count by the T4 that closes the cycle. A grant taken in the wrong state, or enables left on while granted, shows within half a clock: the bench looks at `hold_ack` and both enables after every falling edge as well as after every rising edge. A stale ownership flag shows as `bus_oe` rising after a release with no cycle requested, which the bench watches for over several idle clocks.

// File: rtl/bus_seq.sv
module bus_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  input  logic       ready,
  input  logic       hold_req,
  output logic [2:0] stat,
  output logic       stat_oe,
  output logic       bus_oe,
  output logic       hold_ack,
  output logic       done,
  output logic [2:0] phase
);
  localparam logic [2:0] PH_TI = 3'd0, PH_T1 = 3'd1, PH_T2 = 3'd2,
                         PH_T3 = 3'd3, PH_TW = 3'd4, PH_T4 = 3'd5;
  localparam logic [2:0] PASSIVE = 3'b111;

  logic [2:0] st, st_nx, cur_k, pend_k;
  logic       pend_v, own, hold_q, ack_q, rst_seen, first;

  wire slot  = (st == PH_TI) || (st == PH_T4);
  wire start = slot && pend_v && !ack_q;

  always_comb begin
    case (st)
      PH_TI:        st_nx = start ? PH_T1 : PH_TI;
      PH_T1:        st_nx = PH_T2;
      PH_T2:        st_nx = PH_T3;
      PH_T3, PH_TW: st_nx = ready ? PH_T4 : PH_TW;
      PH_T4:        st_nx = start ? PH_T1 : PH_TI;
      default:      st_nx = PH_TI;
    endcase
  end

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    first    <= rst && !rst_seen;
    if (rst) begin
      st     <= PH_TI;
      pend_v <= 1'b0;
      pend_k <= PASSIVE;
      cur_k  <= PASSIVE;
      own    <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      st     <= st_nx;
      hold_q <= hold_req;
      if (start) begin
        pend_v <= 1'b0;
        cur_k  <= pend_k;
        own    <= 1'b1;
      end else begin
        if (req_valid && !pend_v && req_kind != PASSIVE) begin
          pend_v <= 1'b1;
          pend_k <= req_kind;
        end
        if (ack_q) own <= 1'b0;
      end
    end
  end

  always_ff @(negedge clk) begin
    if (rst)          ack_q <= 1'b0;
    else if (!hold_q) ack_q <= 1'b0;
    else if (slot)    ack_q <= 1'b1;
  end

  always_comb begin
    if (first) stat = PASSIVE;
    else case (st)
      PH_T1, PH_T2: stat = cur_k;
      PH_TI, PH_T4: stat = pend_v ? pend_k : PASSIVE;
      default:      stat = PASSIVE;
    endcase
  end

  assign stat_oe  = first || (!ack_q && (own || (slot && pend_v)));
  assign bus_oe   = own && !ack_q;
  assign hold_ack = ack_q;
  assign done     = (st == PH_T4);
  assign phase    = st;

  // R7
  grant_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> slot);
  // R8
  float_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> (!bus_oe && !stat_oe));
  // R3
  wait_insert_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == PH_T3 || st == PH_TW) && !ready) |=> (st == PH_TW));
  // R4
  passive_data_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_T3 || st == PH_TW) |-> (stat == PASSIVE));
  // R9
  no_midcycle_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_T1 || st == PH_T2 || st == PH_T3 || st == PH_TW) |-> !ack_q);
  // R10
  no_redrive_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_q) |-> !bus_oe);
  // R2
  t1_to_t2_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_T1) |=> (st == PH_T2));
endmodule

// File: tb/tb_bus_seq.sv
module tb_bus_seq;
  logic clk = 0, rst = 0, req_valid = 0, ready = 1, hold_req = 0;
  logic [2:0] req_kind = 0;
  wire [2:0] stat, phase;
  wire stat_oe, bus_oe, hold_ack, done;

  always #4 clk = ~clk;

  bus_seq dut (.clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
               .ready(ready), .hold_req(hold_req), .stat(stat), .stat_oe(stat_oe),
               .bus_oe(bus_oe), .hold_ack(hold_ack), .done(done), .phase(phase));

  typedef struct { logic [2:0] k; int w; } item_t;
  item_t exp_q[$];
  item_t cur;
  int tw = 0, n_cmp = 0, n_bad = 0;
  bit armed = 0, ended = 0, ack_prev = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic issue(logic [2:0] k, int w);
    @(negedge clk); #1;
    req_valid = 1; req_kind = k;
    if (k != 3'd7) exp_q.push_back('{k, w});
    @(negedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_idle;
    for (int g = 0; g < 200 && (exp_q.size() != 0 || phase != 3'd0); g++) begin
      @(posedge clk); #3;
    end
  endtask

  task automatic wait_phase(logic [2:0] p);
    for (int g = 0; g < 60; g++) begin
      @(posedge clk); #2;
      if (phase == p) break;
    end
  endtask

  // scoreboard monitor, rising side
  always @(posedge clk) begin
    #1;
    if (armed) begin
      case (phase)
        3'd1: begin
          if (exp_q.size() == 0) chk(0, "R2 unexpected T1", 1, 0);
          else begin
            cur = exp_q.pop_front();
            chk(stat == cur.k, "R4 T1 status", stat, cur.k);
            chk(bus_oe && stat_oe, "R11 drive in T1", bus_oe, 1);
          end
          tw = 0;
        end
        3'd2: begin
          chk(stat == cur.k, "R4 T2 status", stat, cur.k);
          chk(!done, "R2 done low in T2", done, 0);
        end
        3'd3: begin
          chk(stat == 3'd7, "R4 T3 passive", stat, 7);
          ready = (cur.w == 0);
        end
        3'd4: begin
          chk(stat == 3'd7, "R4 Tw passive", stat, 7);
          tw++;
          ready = (tw >= cur.w);
        end
        3'd5: begin
          chk(tw == cur.w, "R3 wait count", tw, cur.w);
          chk(done, "R2 done in T4", done, 1);
          ready = 1;
        end
        default: ;
      endcase
      chk(!(hold_ack && bus_oe), "R8 enable with grant", bus_oe, 0);
    end
  end

  // falling side: grant slot and float
  always @(negedge clk) begin
    #2;
    if (armed) begin
      if (hold_ack && !ack_prev)
        chk(phase == 3'd0 || phase == 3'd5, "R7 grant slot", phase, 5);
      chk(!(hold_ack && (bus_oe || stat_oe)), "R8 float at grant", bus_oe + stat_oe, 0);
    end
    ack_prev = hold_ack;
  end

  initial begin
    #(8 * 50000);
    chk(0, "R2 watchdog", 0, 1);
    finish_run;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); #1 rst = 1;
    @(posedge clk); #2;
    chk(stat_oe && stat == 3'd7, "R1 first reset clock high", {stat_oe, stat}, 15);
    @(posedge clk); #2;
    chk(!stat_oe, "R1 float after first clock", stat_oe, 0);
    chk(phase == 0 && !hold_ack && !bus_oe && !done, "R1 reset state", phase, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); #1 rst = 0; armed = 1;
    @(posedge clk); #2;
    chk(!stat_oe && !bus_oe && phase == 0, "R1 idle after reset", {stat_oe, bus_oe}, 0);

    // R5: status shown in Ti before T1
    @(negedge clk); #1 req_valid = 1; req_kind = 3'd5; exp_q.push_back('{3'd5, 0});
    @(posedge clk); #2;
    chk(phase == 0 && stat == 3'd5, "R5 code in Ti", stat, 5);
    chk(stat_oe && !bus_oe, "R5 only status driven", {stat_oe, bus_oe}, 2);
    @(negedge clk); #1 req_valid = 0;
    @(posedge clk); #2;
    chk(phase == 3'd1, "R5 T1 next clock", phase, 1);
    wait_idle();
    chk(bus_oe, "R11 bus kept while idle", bus_oe, 1);

    // all codes, varied waits (R2 R3 R4)
    for (int k = 0; k < 7; k++) begin
      issue(k[2:0], (k * 2) % 5);
      wait_idle();
    end

    // R5: code 7 ignored
    issue(3'd7, 0);
    repeat (3) begin
      @(posedge clk); #2;
      chk(phase == 0 && stat == 3'd7, "R5 code 7 ignored", phase, 0);
    end

    // R6: back to back
    issue(3'd3, 1);
    wait_phase(3'd2);
    issue(3'd6, 0);
    wait_phase(3'd5);
    chk(stat == 3'd6 && stat_oe, "R6 next code in T4", stat, 6);
    @(posedge clk); #2;
    chk(phase == 3'd1, "R6 T4 to T1", phase, 1);
    wait_idle();

    // hold in idle (R7 R8)
    @(negedge clk); #1 hold_req = 1;
    @(posedge clk); #2;
    chk(!hold_ack, "R7 no grant at sample edge", hold_ack, 0);
    @(negedge clk); #2;
    chk(hold_ack, "R7 grant mid Ti", hold_ack, 1);
    chk(!bus_oe && !stat_oe, "R8 float with grant", {bus_oe, stat_oe}, 0);

    // R9: request waits during hold
    issue(3'd4, 0);
    repeat (4) begin
      @(posedge clk); #2;
      chk(phase == 0 && !bus_oe, "R9 held in Ti", phase, 0);
    end
    @(negedge clk); #1 hold_req = 0;
    @(posedge clk); #2;
    chk(hold_ack, "R10 ack until falling edge", hold_ack, 1);
    @(negedge clk); #2;
    chk(!hold_ack, "R10 ack drops", hold_ack, 0);
    chk(!bus_oe && stat_oe && stat == 3'd4, "R10 only pending status", {bus_oe, stat_oe}, 1);
    @(posedge clk); #2;
    chk(phase == 3'd1 && bus_oe, "R10 drive from T1", bus_oe, 1);
    wait_idle();

    // R10: release without request
    @(negedge clk); #1 hold_req = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1 hold_req = 0;
    repeat (2) @(negedge clk);
    repeat (3) begin
      @(posedge clk); #2;
      chk(!hold_ack && !bus_oe && !stat_oe, "R10 no redrive", {bus_oe, stat_oe}, 0);
    end

    // R9: hold during a cycle
    issue(3'd1, 2);
    wait_phase(3'd2);
    @(negedge clk); #1 hold_req = 1;
    for (int g = 0; g < 40 && !hold_ack; g++) begin
      @(negedge clk); #2;
    end
    chk(hold_ack && phase == 3'd5, "R9 grant after cycle", phase, 5);
    @(posedge clk); #2;
    chk(phase == 0, "R9 Ti while granted", phase, 0);
    @(negedge clk); #1 hold_req = 0;
    repeat (2) @(negedge clk);
    issue(3'd0, 0);
    wait_idle();

    repeat (3) @(posedge clk);
    finish_run;
  end
endmodule